// File: doc/BRIEF.md
# Five-Stage Multiply-Add Pipeline

This block is an in-order pipeline with five stages (fetch, decode, first execute, second execute, write-back). It runs four arithmetic operations on sixteen 16-bit registers: two-operand add, three-operand add, multiply, and multiply then add. The first execute stage holds one unit that either adds or multiplies. A multiply occupies that unit for two clocks. The second execute stage adds the third operand for the three-operand operations. The two-operand operations pass around that adder on a skip path.

Results move to later instructions through forwarding multiplexers. A two-operand result can be forwarded while it is still in the second execute stage. A three-operand result can be forwarded only from write-back. The third operand is read late, in the second execute stage, so it has its own pair of write-back forwarding muxes. The register file returns the value being written when a read hits the same register in the same clock. Two stall conditions keep the pipeline correct: one for a dependency on a three-operand result, and one for the second multiply clock.

Instruction memory is a plain array inside the block. A loader writes it through a write port, normally while reset is held. Every register write that retires is visible on the write-back port.

Top module: `mac_pipe`

## Requirements
- R1: An instruction word is decoded as follows. Bits [31:28] select the operation: 1 = two-operand add, 2 = three-operand add, 4 = multiply, 8 = multiply-add. Bits [15:12] give the destination register, [11:8] the first source, [7:4] the second source and [3:0] the third source. A word with any other operation code, or with any bit of [27:16] set, is a no-op. A no-op writes no register.
- R2: The results are a+b, a+b+c, a*b and a*b+c, each taken modulo 2^16 with no overflow flag. Every result appears on the write-back port in program order.
- R3: While reset is low, the write-back port is idle and both stall outputs are low. After reset, register k holds the value k and fetch starts at address 0.
- R4: Register 0 can be written and read like any other register.
- R5: A two-operand result, or a multiply result, is forwarded from the second execute stage to the next instruction without a stall. Results two instructions back are forwarded from write-back.
- R6: When a non-no-op instruction reads, as its first or second source, the destination of the three-operand instruction directly ahead of it, `stall_dep_o` is high for exactly one clock. During that clock, fetch and decode hold and a bubble enters the first execute stage. A dependency through the third source alone never stalls.
- R7: Each multiply or multiply-add raises `stall_mul_o` for exactly one clock. During that clock, the multiply stays in the first execute stage, the earlier stages hold, and a bubble goes to the second execute stage.
- R8: A read of a register that write-back is writing in the same clock returns the new value.
- R9: No-ops, including malformed words with nonzero register fields, never forward data and never cause a stall.
- R10: A third source that depends on an instruction one, two or three places ahead gets the correct value with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_addr | input | clog2(IMEM_DEPTH) | Instruction memory write address |
| imem_wdata | input | 32 | Instruction word to store |
| wb_we_o | output | 1 | Register write in progress at write-back |
| wb_addr_o | output | 4 | Destination register being written |
| wb_data_o | output | DW | Value being written |
| stall_dep_o | output | 1 | Dependency stall on a three-operand result |
| stall_mul_o | output | 1 | Extra multiply clock |

## Verification
The assertions assume that instruction memory is not written while the pipeline runs. They also assume that the program never runs far enough for the fetch address to wrap back into code already executed. The stimulus loads each program while reset is held, and releases reset only after loading ends. It then stops each run after fewer clocks than the memory has words, and pads every program with no-op words. The hold and bubble properties assume the stall outputs are the only source of front-end stalls, and the stimulus drives nothing else that could stall the pipeline.

// File: rtl/mac_pkg.sv
// Shared types and decode helpers for the multiply-add pipeline.
// Assumes the fixed 32-bit instruction layout with 4-bit register fields.
package mac_pkg;
    localparam int RAW  = 4;
    localparam int NREG = 1 << RAW;
    localparam int IW   = 32;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_ADD2 = 4'h1,
        OP_ADD3 = 4'h2,
        OP_MUL  = 4'h4,
        OP_MAC  = 4'h8
    } op_e;

    // Map a raw word to an operation; malformed words become no-ops.
    function automatic op_e decode_op(input logic [IW-1:0] w);
        op_e o;
        case (w[31:28])
            4'h1:    o = OP_ADD2;
            4'h2:    o = OP_ADD3;
            4'h4:    o = OP_MUL;
            4'h8:    o = OP_MAC;
            default: o = OP_NOP;
        endcase
        if (w[27:16] != '0) o = OP_NOP;
        return o;
    endfunction

    function automatic logic is_three(input op_e o);
        return (o == OP_ADD3) || (o == OP_MAC);
    endfunction

    function automatic logic is_mul(input op_e o);
        return (o == OP_MUL) || (o == OP_MAC);
    endfunction
endpackage

// File: rtl/mac_imem.sv
// Instruction store: synchronous write, combinational read.
// Assumes DEPTH is a power of two so every address is in range.
module mac_imem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store a loader word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mac_regfile.sv
// Three-read, one-write register file. A read that hits the register being
// written in the same clock returns the incoming value. Reset seeds
// register k with the value k.
module mac_regfile import mac_pkg::*; #(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd,
    input  logic [RAW-1:0] ra_x,
    input  logic [RAW-1:0] ra_y,
    input  logic [RAW-1:0] ra_z,
    output logic [DW-1:0]  rd_x,
    output logic [DW-1:0]  rd_y,
    output logic [DW-1:0]  rd_z
);
    logic [DW-1:0] regs [NREG];

    // Seed on reset, otherwise take the write-back value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs[k] <= DW'(k);
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    // Reads with internal write-through.
    always_comb begin
        rd_x = (we && wa == ra_x) ? wd : regs[ra_x];
        rd_y = (we && wa == ra_y) ? wd : regs[ra_y];
        rd_z = (we && wa == ra_z) ? wd : regs[ra_z];
    end
endmodule

// File: rtl/mac_hazard.sv
// Stall generation. The multiply stall covers the first clock a multiply
// spends in the first execute stage. The dependency stall fires when the
// decoding instruction needs its first or second source from a three-operand
// result still in the first execute stage. The multiply stall wins, so the
// dependency stall output is the effective one.
module mac_hazard import mac_pkg::*; (
    input  logic           id_we,
    input  logic [RAW-1:0] id_xa,
    input  logic [RAW-1:0] id_ya,
    input  logic           e1_we,
    input  op_e            e1_op,
    input  logic [RAW-1:0] e1_ra,
    input  logic           e1_second,
    output logic           stall_m,
    output logic           stall_d
);
    logic raw_d;

    // Stall conditions.
    always_comb begin
        stall_m = e1_we && is_mul(e1_op) && !e1_second;
        raw_d   = id_we && e1_we && is_three(e1_op) &&
                  ((id_xa == e1_ra) || (id_ya == e1_ra));
        stall_d = raw_d && !stall_m;
    end
endmodule

// File: rtl/mac_fwd.sv
// One forwarding mux pair: the near source (second execute stage) has
// priority over the far source (write-back) over the stage's own copy.
// Tie near_en low where only write-back forwarding applies.
module mac_fwd import mac_pkg::*; #(
    parameter int DW = 16
) (
    input  logic [RAW-1:0] src_a,
    input  logic [DW-1:0]  base_d,
    input  logic           near_en,
    input  logic [RAW-1:0] near_ra,
    input  logic [DW-1:0]  near_d,
    input  logic           far_en,
    input  logic [RAW-1:0] far_ra,
    input  logic [DW-1:0]  far_d,
    output logic [DW-1:0]  out_d
);
    // Pick the youngest matching producer.
    always_comb begin
        if (near_en && near_ra == src_a)     out_d = near_d;
        else if (far_en && far_ra == src_a)  out_d = far_d;
        else                                 out_d = base_d;
    end
endmodule

// File: rtl/mac_pipe.sv
// Five-stage multiply-add pipeline top. Assumes instruction memory is
// loaded while reset is held and that programs end in no-op padding.
module mac_pipe import mac_pkg::*; #(
    parameter int DW         = 16,
    parameter int IMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
    input  logic [IW-1:0]                 imem_wdata,
    output logic                          wb_we_o,
    output logic [RAW-1:0]                wb_addr_o,
    output logic [DW-1:0]                 wb_data_o,
    output logic                          stall_dep_o,
    output logic                          stall_mul_o
);
    localparam int IAW = $clog2(IMEM_DEPTH);

    logic [IAW-1:0] pc;
    logic [IW-1:0]  if_word, ifid_word;
    logic           stall_m, stall_d, front_en;

    // ---------------- fetch ----------------
    mac_imem #(.DEPTH(IMEM_DEPTH), .AW(IAW), .W(IW)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
        .raddr(pc), .rdata(if_word)
    );

    assign front_en = !stall_m && !stall_d;

    // Program counter and fetch/decode register, held on any stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            ifid_word <= '0;
        end else if (front_en) begin
            pc        <= pc + 1'b1;
            ifid_word <= if_word;
        end
    end

    // ---------------- decode ----------------
    op_e            id_op;
    logic           id_we;
    logic [RAW-1:0] id_ra, id_xa, id_ya, id_za;
    logic [DW-1:0]  id_x, id_y, id_z;

    assign id_op = decode_op(ifid_word);
    assign id_we = (id_op != OP_NOP);
    assign id_ra = ifid_word[15:12];
    assign id_xa = ifid_word[11:8];
    assign id_ya = ifid_word[7:4];
    assign id_za = ifid_word[3:0];

    logic           w_we;
    logic [RAW-1:0] w_ra;
    logic [DW-1:0]  w_d;

    mac_regfile #(.DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(w_we), .wa(w_ra), .wd(w_d),
        .ra_x(id_xa), .ra_y(id_ya), .ra_z(id_za),
        .rd_x(id_x), .rd_y(id_y), .rd_z(id_z)
    );

    logic           e1_we, e1_second;
    op_e            e1_op;
    logic [RAW-1:0] e1_ra, e1_xa, e1_ya, e1_za;
    logic [DW-1:0]  e1_x, e1_y, e1_z;

    mac_hazard u_hz (
        .id_we(id_we), .id_xa(id_xa), .id_ya(id_ya),
        .e1_we(e1_we), .e1_op(e1_op), .e1_ra(e1_ra), .e1_second(e1_second),
        .stall_m(stall_m), .stall_d(stall_d)
    );

    // ---------------- first execute ----------------
    logic           e2_we, e2_fwd_en;
    op_e            e2_op;
    logic [RAW-1:0] e2_ra, e2_za;
    logic [DW-1:0]  e2_s, e2_z;
    logic [DW-1:0]  fx, fy, fz1, s1;

    assign e2_fwd_en = e2_we && !is_three(e2_op);

    mac_fwd #(.DW(DW)) u_fx (
        .src_a(e1_xa), .base_d(e1_x),
        .near_en(e2_fwd_en), .near_ra(e2_ra), .near_d(e2_s),
        .far_en(w_we), .far_ra(w_ra), .far_d(w_d), .out_d(fx)
    );
    mac_fwd #(.DW(DW)) u_fy (
        .src_a(e1_ya), .base_d(e1_y),
        .near_en(e2_fwd_en), .near_ra(e2_ra), .near_d(e2_s),
        .far_en(w_we), .far_ra(w_ra), .far_d(w_d), .out_d(fy)
    );
    mac_fwd #(.DW(DW)) u_fz1 (
        .src_a(e1_za), .base_d(e1_z),
        .near_en(1'b0), .near_ra('0), .near_d('0),
        .far_en(w_we), .far_ra(w_ra), .far_d(w_d), .out_d(fz1)
    );

    assign s1 = is_mul(e1_op) ? DW'(fx * fy) : DW'(fx + fy);

    // Decode to first-execute register: multiply recaptures forwarded
    // operands, a dependency stall inserts a bubble, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1_we <= 1'b0; e1_op <= OP_NOP; e1_second <= 1'b0;
            e1_ra <= '0; e1_xa <= '0; e1_ya <= '0; e1_za <= '0;
            e1_x  <= '0; e1_y  <= '0; e1_z  <= '0;
        end else if (stall_m) begin
            e1_x <= fx; e1_y <= fy; e1_z <= fz1;
            e1_second <= 1'b1;
        end else if (stall_d) begin
            e1_we <= 1'b0; e1_op <= OP_NOP; e1_second <= 1'b0;
        end else begin
            e1_we <= id_we; e1_op <= id_op; e1_second <= 1'b0;
            e1_ra <= id_ra; e1_xa <= id_xa; e1_ya <= id_ya; e1_za <= id_za;
            e1_x  <= id_x;  e1_y  <= id_y;  e1_z  <= id_z;
        end
    end

    // First to second execute register; bubble on the first multiply clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e2_we <= 1'b0; e2_op <= OP_NOP;
            e2_ra <= '0; e2_za <= '0; e2_s <= '0; e2_z <= '0;
        end else if (stall_m) begin
            e2_we <= 1'b0; e2_op <= OP_NOP;
        end else begin
            e2_we <= e1_we; e2_op <= e1_op;
            e2_ra <= e1_ra; e2_za <= e1_za; e2_s <= s1; e2_z <= fz1;
        end
    end

    // ---------------- second execute ----------------
    logic [DW-1:0] fz2, e2_res;

    mac_fwd #(.DW(DW)) u_fz2 (
        .src_a(e2_za), .base_d(e2_z),
        .near_en(1'b0), .near_ra('0), .near_d('0),
        .far_en(w_we), .far_ra(w_ra), .far_d(w_d), .out_d(fz2)
    );

    assign e2_res = is_three(e2_op) ? DW'(e2_s + fz2) : e2_s;

    // Second execute to write-back register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_we <= 1'b0; w_ra <= '0; w_d <= '0;
        end else begin
            w_we <= e2_we; w_ra <= e2_ra; w_d <= e2_res;
        end
    end

    assign wb_we_o     = w_we;
    assign wb_addr_o   = w_ra;
    assign wb_data_o   = w_d;
    assign stall_dep_o = stall_d;
    assign stall_mul_o = stall_m;

    // ---------------- assertions ----------------
    p_reset_quiet_r3: assert property (@(posedge clk) !rst_n |=> !wb_we_o);

    p_mul_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_mul_o |=> !stall_mul_o);

    p_mul_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_mul_o |=> (e1_we && is_mul(e1_op) && $stable(e1_ra)));

    p_mul_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_mul_o |=> !e2_we);

    p_dep_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_dep_o |=> !e1_we);

    p_front_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_dep_o || stall_mul_o) |=> ($stable(pc) && $stable(ifid_word)));

    p_no_late_three_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(e1_we && e2_we && is_three(e2_op) &&
          (e2_ra == e1_xa || e2_ra == e1_ya)));
endmodule

// File: tb/sim_mac_pipe.sv
// Scoreboard bench: the driver builds each program and pushes expected
// register writes; the monitor pops and compares them at write-back.
module sim_mac_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int IAW        = 6;
    localparam int DW         = 16;
    localparam int RUN_CYC    = 62;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            imem_we = 1'b0;
    logic [IAW-1:0]  imem_addr = '0;
    logic [31:0]     imem_wdata = '0;
    logic            wb_we_o, stall_dep_o, stall_mul_o;
    logic [3:0]      wb_addr_o;
    logic [DW-1:0]   wb_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_pipe #(.DW(DW), .IMEM_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .wb_we_o(wb_we_o), .wb_addr_o(wb_addr_o),
        .wb_data_o(wb_data_o), .stall_dep_o(stall_dep_o),
        .stall_mul_o(stall_mul_o)
    );

    typedef struct packed { logic [3:0] ra; logic [DW-1:0] d; } item_t;

    int          n_chk = 0, n_bad = 0;
    logic [31:0] prog [DEPTH];
    int          plen;
    logic [DW-1:0] mdl [16];
    item_t       expq [$];
    int          exp_dep, exp_mul, got_dep, got_mul;
    bit          mon_on = 1'b0;
    bit          prev_ok;
    logic [3:0]  prev_op, prev_r;
    string       cur_req = "R2";

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic start_prog(input string req);
        cur_req = req;
        plen = 0;
        expq.delete();
        for (int k = 0; k < 16; k++) mdl[k] = DW'(k);   // R3 seed
        exp_dep = 0; exp_mul = 0; got_dep = 0; got_mul = 0;
        prev_ok = 1'b0; prev_op = 4'h0; prev_r = 4'h0;
    endtask

    // Driver: model the word, push the expected write, predict stalls.
    task automatic emit_raw(input logic [31:0] w);
        logic [3:0]    op, r, xa, ya, za;
        logic          ok;
        logic [DW-1:0] a, b, c, res;
        logic [31:0]   p;
        op = w[31:28]; r = w[15:12]; xa = w[11:8]; ya = w[7:4]; za = w[3:0];
        ok = (w[27:16] == 12'h0) &&
             (op == 4'h1 || op == 4'h2 || op == 4'h4 || op == 4'h8);
        a = mdl[xa]; b = mdl[ya]; c = mdl[za];
        p = 32'(a) * 32'(b);
        case (op)
            4'h1:    res = a + b;
            4'h2:    res = a + b + c;
            4'h4:    res = p[DW-1:0];
            default: res = p[DW-1:0] + c;
        endcase
        if (ok) begin
            mdl[r] = res;
            expq.push_back('{ra: r, d: res});
            if (prev_ok && (prev_op == 4'h2 || prev_op == 4'h8) &&
                (xa == prev_r || ya == prev_r)) exp_dep++;
            if (op == 4'h4 || op == 4'h8) exp_mul++;
        end
        prev_ok = ok; prev_op = op; prev_r = r;
        prog[plen] = w;
        plen++;
    endtask

    task automatic emit(input logic [3:0] op, input logic [3:0] r,
                        input logic [3:0] x, input logic [3:0] y,
                        input logic [3:0] z);
        emit_raw({op, 12'h000, r, x, y, z});
    endtask

    task automatic run_prog();
        rst_n = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            imem_we = 1'b1;
            imem_addr = IAW'(a);
            imem_wdata = (a < plen) ? prog[a] : 32'h0;
        end
        @(negedge clk);
        imem_we = 1'b0;
        check("R3 idle write-back in reset", 32'(wb_we_o), 32'h0);
        check("R3 stalls low in reset", {30'h0, stall_dep_o, stall_mul_o}, 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (RUN_CYC) @(negedge clk);
        mon_on = 1'b0;
        check({cur_req, " R2 all writes retired"}, 32'(expq.size()), 32'h0);
        check({cur_req, " R6 dependency stall cycles"}, 32'(got_dep), 32'(exp_dep));
        check({cur_req, " R7 multiply stall cycles"}, 32'(got_mul), 32'(exp_mul));
        rst_n = 1'b0;
    endtask

    // Monitor: compare every retired write with the scoreboard head.
    always @(negedge clk) begin
        if (mon_on) begin
            if (stall_dep_o) got_dep++;
            if (stall_mul_o) got_mul++;
            if (wb_we_o) begin
                if (expq.size() == 0) begin
                    check({cur_req, " R9 unexpected write"},
                          {12'h0, wb_addr_o, wb_data_o}, 32'hFFFF_FFFF);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    check(cur_req, {12'h0, wb_addr_o, wb_data_o},
                          {12'h0, it.ra, it.d});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 R2 R4: each operation, wrap-around, register 0 as a target.
        start_prog("R1 R2 R4");
        emit(4'h1, 4'd1, 4'd2, 4'd3, 4'd0);
        emit(4'h2, 4'd4, 4'd5, 4'd6, 4'd7);
        emit(4'h4, 4'd8, 4'd9, 4'd10, 4'd0);
        emit(4'h8, 4'd11, 4'd12, 4'd13, 4'd14);
        emit(4'h1, 4'd0, 4'd15, 4'd15, 4'd0);
        emit(4'h1, 4'd1, 4'd0, 4'd0, 4'd0);
        emit(4'h4, 4'd3, 4'd15, 4'd14, 4'd0);
        emit(4'h4, 4'd3, 4'd3, 4'd3, 4'd0);
        emit(4'h4, 4'd3, 4'd3, 4'd3, 4'd0);
        emit(4'h2, 4'd6, 4'd3, 4'd3, 4'd3);
        run_prog();

        // R5 R8: forwarding from the second execute stage and write-back,
        // and register-file write-through at distance three.
        start_prog("R5 R8");
        emit(4'h1, 4'd1, 4'd1, 4'd2, 4'd0);
        emit(4'h1, 4'd1, 4'd1, 4'd1, 4'd0);
        emit(4'h4, 4'd2, 4'd1, 4'd3, 4'd0);
        emit(4'h1, 4'd4, 4'd2, 4'd2, 4'd0);
        emit(4'h1, 4'd5, 4'd6, 4'd7, 4'd0);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h1, 4'd8, 4'd5, 4'd5, 4'd0);
        emit(4'h1, 4'd9, 4'd9, 4'd10, 4'd0);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h1, 4'd10, 4'd9, 4'd11, 4'd0);
        run_prog();

        // R6 R7: dependency stalls after three-operand results, alone and
        // after a multiply-add; a third-source-only dependency does not stall.
        start_prog("R6 R7");
        emit(4'h2, 4'd5, 4'd1, 4'd2, 4'd3);
        emit(4'h1, 4'd6, 4'd5, 4'd1, 4'd0);
        emit(4'h8, 4'd7, 4'd2, 4'd3, 4'd4);
        emit(4'h4, 4'd8, 4'd7, 4'd7, 4'd0);
        emit(4'h2, 4'd9, 4'd1, 4'd1, 4'd1);
        emit(4'h2, 4'd10, 4'd2, 4'd2, 4'd9);
        emit(4'h2, 4'd11, 4'd10, 4'd11, 4'd10);
        emit(4'h8, 4'd12, 4'd11, 4'd12, 4'd11);
        run_prog();

        // R9: malformed words with register fields, and no-op juniors.
        start_prog("R9");
        emit_raw(32'h3000_5123);
        emit(4'h1, 4'd6, 4'd5, 4'd0, 4'd0);
        emit_raw(32'h1001_7120);
        emit(4'h1, 4'd8, 4'd7, 4'd7, 4'd0);
        emit(4'h2, 4'd0, 4'd1, 4'd2, 4'd3);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h1, 4'd1, 4'd0, 4'd0, 4'd0);
        emit(4'h2, 4'd4, 4'd4, 4'd4, 4'd4);
        emit_raw(32'hC000_9440);
        emit(4'h1, 4'd9, 4'd9, 4'd4, 4'd0);
        run_prog();

        // R10: third-source dependencies at distances one, two and three.
        start_prog("R10");
        emit(4'h1, 4'd3, 4'd1, 4'd1, 4'd0);
        emit(4'h2, 4'd4, 4'd1, 4'd2, 4'd3);
        emit(4'h8, 4'd5, 4'd2, 4'd2, 4'd3);
        emit(4'h4, 4'd6, 4'd2, 4'd7, 4'd0);
        emit(4'h8, 4'd7, 4'd1, 4'd1, 4'd6);
        emit(4'h2, 4'd8, 4'd0, 4'd0, 4'd7);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h2, 4'd9, 4'd0, 4'd0, 4'd8);
        emit(4'h1, 4'd10, 4'd1, 4'd1, 4'd0);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        emit(4'h8, 4'd11, 4'd1, 4'd1, 4'd10);
        run_prog();

        // Mixed programs covering R2 R5 R6 R7 R10 together.
        for (int s = 0; s < 4; s++) begin
            start_prog("R2 R5 R6 R7 R10 mixed");
            void'($urandom(32'(s) * 977 + 13));
            for (int i = 0; i < 20; i++) begin
                logic [3:0] ops [5];
                logic [3:0] o;
                ops[0] = 4'h0; ops[1] = 4'h1; ops[2] = 4'h2;
                ops[3] = 4'h4; ops[4] = 4'h8;
                o = ops[$urandom_range(4, 0)];
                emit(o, 4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
                     4'($urandom_range(15, 0)),
                     (o == 4'h2 || o == 4'h8) ? 4'($urandom_range(15, 0)) : 4'h0);
            end
            run_prog();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule